// File: doc/BRIEF.md
# Serial Divider Control Loader

This block is the receive side of a three-wire programming port: a serial clock, a serial data line and a latch enable. Bits shift in most significant first, one per rising serial clock edge, into an 18-bit shift register. On a rising edge of latch enable, the low bit of that register acts as a select. When it is 0, the upper 17 bits are committed to a held divider control word. When it is 1, the word is meant for some other register and this block leaves its held state alone.

The held word is split into four outputs: a 10-bit program count, a 5-bit swallow count, a counter-reset flag and a power-down flag. A one-cycle update strobe marks every commit, so a downstream divider can reload on that strobe.

All three port pins are asynchronous to the system clock. Each passes through a two-stage synchronizer, and edges are detected after that. An asynchronous active-low reset clears both the shift register and the held word.

Top module: `serial_div_loader`

## Requirements
- R1: While `rstN` is low, all outputs are 0 and the shift register is cleared. A latch right after reset therefore commits an all-zero word.
- R2: Each rising edge of `serClk` shifts `serData` into bit 0, and the older bits move up. Only the last 18 bits shifted are kept, and the first of those ends in bit 17.
- R3: On a rising edge of `latchEn` with shift bit 0 equal to 0, shift bits 17..1 become the held word. This happens again on every such edge, even if no new bits were shifted in.
- R4: On a rising edge of `latchEn` with shift bit 0 equal to 1, the held outputs stay unchanged and no update strobe is produced.
- R5: `bCount` equals held word bits 16..7, which are shift bits 17..8.
- R6: `aCount` equals held word bits 6..2, which are shift bits 7..3.
- R7: `cntReset` equals held word bit 1 (shift bit 2), and `powerDown` equals held word bit 0 (shift bit 1).
- R8: `updateStb` is high for exactly one clock for each committing latch edge, no matter how long `latchEn` stays high. The strobe and the new outputs appear on the third rising `clk` edge after `clk` first samples `latchEn` high.
- R9: One `serClk` high phase shifts exactly one bit, whatever its length. Falling edges, and changes on `serData` while `serClk` stays high, do not shift.
- R10: The held outputs change only in the cycle where `updateStb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock, asynchronous |
| serData | input | 1 | Serial data, MSB first |
| latchEn | input | 1 | Latch enable, commits on a rising edge |
| bCount | output | 10 | Program (B) count |
| aCount | output | 5 | Swallow (A) count |
| cntReset | output | 1 | Counter-reset control flag |
| powerDown | output | 1 | Power-down control flag |
| updateStb | output | 1 | One-cycle pulse on each commit |

## Verification
Several distinct patterns are loaded, and a behavioural model predicts all outputs on every clock:

- Words with mixed field values show whether the field boundaries sit in the right place.
- An all-ones payload catches bits that get truncated or stuck.
- A word with select bit 1, sent after a committed word, must leave that earlier word untouched.
- A stream longer than 18 bits checks that only the last 18 are kept.
- A second latch with no new shifting checks that the same contents commit again.
- A reset in the middle of the run, followed directly by a latch, must commit zeros.

Long `serClk` high phases with `serData` toggling inside them, and long `latchEn` pulses, separate true edge detection from level sensing.

// File: rtl/divload_pkg.sv
package divload_pkg;
  typedef struct packed {
    logic shift;
    logic latch;
  } loadStrobe_t;
endpackage

// File: rtl/divload_sync.sv
module divload_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg <= '0;
        else       stg <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg <= '0;
        else       stg <= {stg[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/divload_ctrl.sv
module divload_ctrl
  import divload_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        latchEn,
  output loadStrobe_t stb,
  output logic        dataBit
);
  localparam int PINS = 3;

  logic [PINS-1:0] syncOut;
  logic clkPrev, lePrev;

  divload_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({serClk, latchEn, serData}),
    .dout(syncOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      lePrev  <= 1'b0;
    end else begin
      clkPrev <= syncOut[2];
      lePrev  <= syncOut[1];
    end
  end

  assign stb.shift = syncOut[2] & ~clkPrev;
  assign stb.latch = syncOut[1] & ~lePrev;
  assign dataBit   = syncOut[0];

  AST_SHIFT_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |=> !stb.shift); // R9
  AST_LATCH_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    stb.latch |=> !stb.latch); // R8
endmodule

// File: rtl/divload_dp.sv
module divload_dp
  import divload_pkg::*;
#(
  parameter int PAY_W = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  loadStrobe_t      stb,
  input  logic             dataBit,
  output logic [PAY_W-1:0] ctrlWord,
  output logic             updateStb
);
  localparam int WORD_W = PAY_W + 1;

  logic [WORD_W-1:0] shiftReg;
  logic commit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          shiftReg <= '0;
    else if (stb.shift) shiftReg <= {shiftReg[WORD_W-2:0], dataBit};
  end

  assign commit = stb.latch & ~shiftReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlWord  <= '0;
      updateStb <= 1'b0;
    end else begin
      updateStb <= commit;
      if (commit) ctrlWord <= shiftReg[WORD_W-1:1];
    end
  end

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |=> shiftReg[0] == $past(dataBit)); // R2
  AST_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latch && !shiftReg[0]) |=> (updateStb && ctrlWord == $past(shiftReg[WORD_W-1:1]))); // R3
  AST_ADDR_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latch && shiftReg[0]) |=> (!updateStb && $stable(ctrlWord))); // R4
  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    updateStb |=> !updateStb); // R8
endmodule

// File: rtl/serial_div_loader.sv
module serial_div_loader
  import divload_pkg::*;
#(
  parameter int B_W         = 10,
  parameter int A_W         = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           serClk,
  input  logic           serData,
  input  logic           latchEn,
  output logic [B_W-1:0] bCount,
  output logic [A_W-1:0] aCount,
  output logic           cntReset,
  output logic           powerDown,
  output logic           updateStb
);
  localparam int CTL_W = 2;
  localparam int PAY_W = B_W + A_W + CTL_W;

  loadStrobe_t      stb;
  logic             dataBit;
  logic [PAY_W-1:0] ctrlWord;

  divload_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .serClk (serClk),
    .serData(serData),
    .latchEn(latchEn),
    .stb    (stb),
    .dataBit(dataBit)
  );

  divload_dp #(.PAY_W(PAY_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .dataBit  (dataBit),
    .ctrlWord (ctrlWord),
    .updateStb(updateStb)
  );

  assign bCount    = ctrlWord[PAY_W-1 -: B_W];
  assign aCount    = ctrlWord[CTL_W +: A_W];
  assign cntReset  = ctrlWord[1];
  assign powerDown = ctrlWord[0];

  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !updateStb |-> $stable({bCount, aCount, cntReset, powerDown})); // R10
endmodule

// File: tb/serial_div_loader_bench.sv
module serial_div_loader_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, latchEn = 1'b0;
  logic [9:0] bCount;
  logic [4:0] aCount;
  logic cntReset, powerDown, updateStb;

  int nChecks = 0, nFail = 0, stbSeen = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  serial_div_loader u_serial_div_loader (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .latchEn(latchEn),
    .bCount(bCount), .aCount(aCount), .cntReset(cntReset), .powerDown(powerDown),
    .updateStb(updateStb)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: pin history queue, newest first
  logic [2:0]  hist[$];
  logic [17:0] mShift;
  logic [16:0] mCtrl;
  logic        mStb;

  always @(posedge clk) begin
    if (!rstN) begin
      mShift = '0; mCtrl = '0; mStb = 1'b0;
      hist = {3'b0, 3'b0, 3'b0};
    end else begin
      logic [2:0]  cur, prv;
      logic [17:0] nxt;
      cur = hist[1]; prv = hist[2];
      nxt = mShift; mStb = 1'b0;
      if (cur[2] && !prv[2]) nxt = {mShift[16:0], cur[0]};
      if (cur[1] && !prv[1] && !mShift[0]) begin
        mCtrl = mShift[17:1];
        mStb = 1'b1;
      end
      mShift = nxt;
      hist.push_front({serClk, latchEn, serData});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R5 per-cycle bCount", bCount, mCtrl[16:7]);
      chk("R6 per-cycle aCount", aCount, mCtrl[6:2]);
      chk("R7 per-cycle control", {cntReset, powerDown}, mCtrl[1:0]);
      chk("R8 per-cycle strobe", updateStb, mStb);
      if (updateStb) stbSeen++;
    end
  end

  task automatic sendBit(logic b);
    @(negedge clk) serData = b; serClk = 1'b0;
    repeat (3) @(negedge clk);
    serClk = 1'b1;
    repeat (2) @(negedge clk);
    serData = ~b; // R9: data motion while serClk is high must not shift
    repeat (3) @(negedge clk);
    serClk = 1'b0;
  endtask

  task automatic sendWord(logic [17:0] w);
    for (int i = 17; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic pulseLatch();
    stbSeen = 0;
    @(negedge clk) latchEn = 1'b1;
    repeat (8) @(negedge clk);
    latchEn = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [17:0] mk(logic [9:0] b, logic [4:0] a, logic cr, logic pd, logic sel);
    return {b, a, cr, pd, sel};
  endfunction

  task automatic expectOut(string tag, logic [9:0] b, logic [4:0] a, logic cr, logic pd, int strobes);
    chk({tag, " R5 bCount"}, bCount, b);
    chk({tag, " R6 aCount"}, aCount, a);
    chk({tag, " R7 cntReset"}, cntReset, cr);
    chk({tag, " R7 powerDown"}, powerDown, pd);
    chk({tag, " R8 strobe count"}, stbSeen, strobes);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {bCount, aCount, cntReset, powerDown, updateStb}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R3 basic commit
    sendWord(mk(10'h2A5, 5'h13, 1'b1, 1'b0, 1'b0));
    pulseLatch();
    expectOut("R3 commit", 10'h2A5, 5'h13, 1'b1, 1'b0, 1);

    // R4 select bit 1 ignored
    sendWord(mk(10'h0F0, 5'h0C, 1'b0, 1'b1, 1'b1));
    pulseLatch();
    expectOut("R4 ignored", 10'h2A5, 5'h13, 1'b1, 1'b0, 0);

    // R2 overlong stream: only last 18 bits kept
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    sendWord(mk(10'h155, 5'h0A, 1'b0, 1'b1, 1'b0));
    pulseLatch();
    expectOut("R2 last18", 10'h155, 5'h0A, 1'b0, 1'b1, 1);

    // all-ones payload
    sendWord(mk(10'h3FF, 5'h1F, 1'b1, 1'b1, 1'b0));
    pulseLatch();
    expectOut("R5 ones", 10'h3FF, 5'h1F, 1'b1, 1'b1, 1);

    // R3 relatch without shifting
    pulseLatch();
    expectOut("R3 relatch", 10'h3FF, 5'h1F, 1'b1, 1'b1, 1);

    // R1 mid-run reset, then latch commits zeros
    @(negedge clk) rstN = 1'b0;
    #1;
    chk("R1 async clear", {bCount, aCount, cntReset, powerDown, updateStb}, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    pulseLatch();
    expectOut("R1 cleared shift", 10'h000, 5'h00, 1'b0, 1'b0, 1);

    // mixed pattern after reset
    sendWord(mk(10'h003, 5'h01, 1'b0, 1'b0, 1'b0));
    pulseLatch();
    expectOut("R6 small", 10'h003, 5'h01, 1'b0, 1'b0, 1);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule